// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table from memory. It accepts one translation request at a time, carrying the address, a read/write flag and a 5-bit requester ID. It captures the directory base for that request and issues one table fetch per level on a simple memory read port. Each fetch is a one-cycle request pulse, followed some cycles later by a one-cycle response that carries data and an error flag. No translation is cached between walks.

The walk ends in one of three outcomes, reported by a one-cycle completion pulse:
- a translated address, together with the six cache-attribute bits of the leaf entry, which are passed through unchanged;
- a page fault, caused by a missing entry or a missing permission;
- a bus error, caused by an error response on either fetch.

On a page fault the block also keeps the faulting address, the access direction and the requester ID. These stay on dedicated outputs until the next page fault, so that status logic next to the block can read them.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid and done_valid are 0, and flt_va, flt_write and flt_id are 0.
- R2: The cycle after a request is accepted (req_valid and req_ready high at a clock edge), mem_req_valid is 1 and mem_req_addr equals dir_base + 4 × req_va[31:22]. Both dir_base and req_va are the values sampled at acceptance.
- R3: When the first-level entry is usable, the cycle after its response the block issues the second fetch. Its address is (first-level entry with bit 0 cleared) + 4 × va[21:12].
- R4: A successful walk raises done_valid for exactly one cycle, the cycle after the second response. In that cycle:
  - done_pa = {leaf[31:12], va[11:0]};
  - done_attr = leaf[8:3];
  - done_fault = 0 and done_bus_err = 0;
  - leaf bits 11:9 are ignored.
- R5: A first-level entry with bit 0 (present) clear ends the walk with done_fault = 1 the cycle after its response, and no second fetch is issued.
- R6: A second-level entry with bit 0 clear ends the walk with done_fault = 1.
- R7: Permissions are checked on the leaf entry:
  - a read (write flag 0) needs leaf bit 1;
  - a write (write flag 1) needs leaf bit 2;
  - a missing permission gives done_fault = 1.
- R8: A response with mem_rsp_err = 1 at either level ends the walk at that level with done_bus_err = 1 and done_fault = 0. It leaves flt_va, flt_write and flt_id unchanged.
- R9: On a page fault, flt_va, flt_write and flt_id take the request's address, write flag and ID in the same cycle that done_valid rises. They hold those values until the next page fault.
- R10: Only one fetch is ever outstanding:
  - req_ready stays 0 from acceptance until done_valid;
  - mem_req_valid is never high two cycles in a row;
  - requests presented while busy are ignored;
  - a response arriving when no fetch is pending is ignored.
- R11: done_pa and done_attr are 0 after a page fault or a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_id | input | 5 | Requester identifier |
| dir_base | input | 32 | Base address of the first-level table |
| mem_req_valid | output | 1 | One-cycle table fetch request |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | One-cycle fetch response |
| mem_rsp_data | input | 32 | Fetched table entry |
| mem_rsp_err | input | 1 | Fetch ended with a bus error |
| done_valid | output | 1 | One-cycle walk completion |
| done_pa | output | 32 | Translated physical address |
| done_attr | output | 6 | Leaf cache-attribute bits, passed through |
| done_fault | output | 1 | Walk ended in a page fault |
| done_bus_err | output | 1 | Walk ended in a bus error |
| flt_va | output | 32 | Address of the last page fault |
| flt_write | output | 1 | Direction of the last page fault |
| flt_id | output | 5 | Requester ID of the last page fault |

## Verification
The assertions assume that the memory returns at most one response per fetch, and only at least one cycle after the fetch pulse. They also assume that no request is accepted in any cycle other than one where req_ready is high. The bench models the memory inside a task that answers each fetch exactly once, after a latency of one to three cycles. Its only deliberate breach is a stray response while the block is idle, which R10 says must be ignored. The bench checks that case at the ports before the next walk starts.

// File: rtl/ptw_pkg.sv
// Shared types and entry field positions for the page table walker.
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT
    } walk_state_t;

    localparam int PRESENT_BIT = 0;
    localparam int READ_BIT    = 1;
    localparam int WRITE_BIT   = 2;
    localparam int ATTR_LSB    = 3;
    localparam int ATTR_W      = 6;
endpackage

// File: rtl/ptw_entry_check.sv
// Decides whether a fetched table entry lets the walk continue.
// Assumes: permissions only matter on the leaf (second-level) entry.
module ptw_entry_check (
    input  logic present,
    input  logic rd_perm,
    input  logic wr_perm,
    input  logic is_leaf,
    input  logic is_write,
    output logic entry_fault
);
    logic access_ok;

    // Permission match for the leaf; directory entries need only presence.
    always_comb begin
        access_ok   = is_leaf ? (is_write ? wr_perm : rd_perm) : 1'b1;
        entry_fault = !present || !access_ok;
    end
endmodule

// File: rtl/ptw_fsm.sv
// Walk sequencer: one fetch per level, strictly one outstanding.
// Assumes: responses come no earlier than the cycle after the fetch pulse.
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_valid,
    input  logic rsp_err,
    input  logic entry_fault,
    output logic req_ready,
    output logic mem_req_valid,
    output logic l2_issue,
    output logic is_leaf,
    output logic take_l1,
    output logic finish,
    output logic finish_fault,
    output logic finish_bus
);
    walk_state_t state, state_nx;
    logic in_wait, rsp_here;

    // Decode of the current state into control strobes.
    always_comb begin
        in_wait       = (state == ST_L1_WAIT) || (state == ST_L2_WAIT);
        rsp_here      = in_wait && rsp_valid;
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1_ISSUE) || (state == ST_L2_ISSUE);
        l2_issue      = (state == ST_L2_ISSUE);
        is_leaf       = (state == ST_L2_WAIT);
        finish_bus    = rsp_here && rsp_err;
        finish_fault  = rsp_here && !rsp_err && entry_fault;
        take_l1       = rsp_here && !rsp_err && !entry_fault && !is_leaf;
        finish        = rsp_here && (rsp_err || entry_fault || is_leaf);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_L1_ISSUE;
            ST_L1_ISSUE: state_nx = ST_L1_WAIT;
            ST_L1_WAIT:  if (rsp_valid) state_nx = take_l1 ? ST_L2_ISSUE : ST_IDLE;
            ST_L2_ISSUE: state_nx = ST_L2_WAIT;
            ST_L2_WAIT:  if (rsp_valid) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/ptw_fault_capture.sv
// Holds the address, direction and requester of the most recent page fault.
// Assumes: capture is a single-cycle strobe at walk end.
module ptw_fault_capture #(
    parameter int VA_W = 32,
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [VA_W-1:0] va,
    input  logic            is_write,
    input  logic [ID_W-1:0] id,
    output logic [VA_W-1:0] flt_va,
    output logic            flt_write,
    output logic [ID_W-1:0] flt_id
);
    // Latch fault context; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_va    <= '0;
            flt_write <= 1'b0;
            flt_id    <= '0;
        end else if (capture) begin
            flt_va    <= va;
            flt_write <= is_write;
            flt_id    <= id;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker top. Captures a request, fetches the directory
// entry and the leaf entry, and reports translation, page fault or bus error.
// Assumes: entries are 4 bytes wide and tables are indexed by VA slices.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int ID_W  = 5,
    localparam int VA_W = 2 * IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_id,
    input  logic [VA_W-1:0]   dir_base,
    output logic              mem_req_valid,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done_valid,
    output logic [VA_W-1:0]   done_pa,
    output logic [ATTR_W-1:0] done_attr,
    output logic              done_fault,
    output logic              done_bus_err,
    output logic [VA_W-1:0]   flt_va,
    output logic              flt_write,
    output logic [ID_W-1:0]   flt_id
);
    localparam int L2_LSB = OFF_W;
    localparam int L1_LSB = OFF_W + IDX_W;

    logic [VA_W-1:0]  va_q, base_q;
    logic             wr_q;
    logic [ID_W-1:0]  id_q;
    logic [IDX_W-1:0] idx_sel;
    logic l2_issue, is_leaf, take_l1, finish, finish_fault, finish_bus;
    logic entry_fault, finish_ok;

    ptw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .rsp_valid    (mem_rsp_valid),
        .rsp_err      (mem_rsp_err),
        .entry_fault  (entry_fault),
        .req_ready    (req_ready),
        .mem_req_valid(mem_req_valid),
        .l2_issue     (l2_issue),
        .is_leaf      (is_leaf),
        .take_l1      (take_l1),
        .finish       (finish),
        .finish_fault (finish_fault),
        .finish_bus   (finish_bus)
    );

    ptw_entry_check u_check (
        .present    (mem_rsp_data[PRESENT_BIT]),
        .rd_perm    (mem_rsp_data[READ_BIT]),
        .wr_perm    (mem_rsp_data[WRITE_BIT]),
        .is_leaf    (is_leaf),
        .is_write   (wr_q),
        .entry_fault(entry_fault)
    );

    ptw_fault_capture #(.VA_W(VA_W), .ID_W(ID_W)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (finish_fault),
        .va       (va_q),
        .is_write (wr_q),
        .id       (id_q),
        .flt_va   (flt_va),
        .flt_write(flt_write),
        .flt_id   (flt_id)
    );

    // Fetch address: current table base plus entry index times four.
    always_comb begin
        idx_sel      = l2_issue ? va_q[L2_LSB +: IDX_W] : va_q[L1_LSB +: IDX_W];
        mem_req_addr = base_q + (VA_W'(idx_sel) << 2);
        finish_ok    = finish && !finish_fault && !finish_bus;
    end

    // Request context and table base; base switches to the level-two table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            id_q   <= '0;
            base_q <= '0;
        end else if (req_valid && req_ready) begin
            va_q   <= req_va;
            wr_q   <= req_write;
            id_q   <= req_id;
            base_q <= dir_base;
        end else if (take_l1) begin
            base_q <= mem_rsp_data & ~VA_W'(1);
        end
    end

    // Walk result registers with a one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid   <= 1'b0;
            done_pa      <= '0;
            done_attr    <= '0;
            done_fault   <= 1'b0;
            done_bus_err <= 1'b0;
        end else begin
            done_valid <= finish;
            if (finish) begin
                done_fault   <= finish_fault;
                done_bus_err <= finish_bus;
                done_pa      <= finish_ok ? {mem_rsp_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
                done_attr    <= finish_ok ? mem_rsp_data[ATTR_LSB +: ATTR_W] : '0;
            end
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol checker for the walker, attached by bind.
// Assumes: the memory answers each fetch once, at least a cycle later.
module ptw_walker_chk #(
    parameter int VA_W = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            mem_req_valid,
    input logic            done_valid,
    input logic [VA_W-1:0] done_pa,
    input logic            done_fault,
    input logic            done_bus_err,
    input logic [VA_W-1:0] flt_va
);
    logic [VA_W-1:0] va_seen;

    // Shadow copy of the accepted address.
    always_ff @(posedge clk) begin
        if (!rst_n)                      va_seen <= '0;
        else if (req_valid && req_ready) va_seen <= req_va;
    end

    assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    assert_single_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !(done_fault && done_bus_err));
    assert_page_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault && !done_bus_err) |-> done_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]);
    assert_fault_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> flt_va == va_seen);
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .mem_req_valid(mem_req_valid),
    .done_valid   (done_valid),
    .done_pa      (done_pa),
    .done_fault   (done_fault),
    .done_bus_err (done_bus_err),
    .flt_va       (flt_va)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_va = 0;
    logic        req_write = 0;
    logic [4:0]  req_id = 0;
    logic [31:0] dir_base = 0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        mem_rsp_err = 0;
    logic        done_valid;
    logic [31:0] done_pa;
    logic [5:0]  done_attr;
    logic        done_fault, done_bus_err;
    logic [31:0] flt_va;
    logic        flt_write;
    logic [4:0]  flt_id;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    logic [31:0] exp_fva = 0;
    logic        exp_fwr = 0;
    logic [4:0]  exp_fid = 0;

    always #5 clk = ~clk;

    ptw_walker u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                nchk++; nerr++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic wr, input logic [4:0] id,
                        input logic [31:0] base, input logic [31:0] l1, input logic l1e,
                        input logic [31:0] l2, input logic l2e, input int lat, input bit stray);
        logic [31:0] a1, a2, epa;
        logic [5:0]  eattr;
        logic go2, efault, ebus;
        a1  = base + {20'd0, va[31:22], 2'b00};
        a2  = (l1 & 32'hFFFF_FFFE) + {20'd0, va[21:12], 2'b00};
        go2 = !l1e && l1[0];
        ebus = l1e || (go2 && l2e);
        efault = !ebus && (!l1[0] || !l2[0] || (wr ? !l2[2] : !l2[1]));
        epa   = (!ebus && !efault) ? {l2[31:12], va[11:0]} : 32'h0;
        eattr = (!ebus && !efault) ? l2[8:3] : 6'h0;
        if (efault) begin exp_fva = va; exp_fwr = wr; exp_fid = id; end

        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr; req_id = id; dir_base = base;
        @(negedge clk);
        req_valid = 0;
        chk("R2 l1 fetch valid", {31'd0, mem_req_valid}, 32'd1);
        chk("R2 l1 fetch addr", mem_req_addr, a1);
        chk("R10 ready low busy", {31'd0, req_ready}, 32'd0);
        if (stray) begin req_valid = 1; req_va = ~va; req_write = ~wr; end
        repeat (lat) @(negedge clk);
        chk("R10 single fetch", {31'd0, mem_req_valid}, 32'd0);
        req_valid = 0;
        mem_rsp_valid = 1; mem_rsp_data = l1; mem_rsp_err = l1e;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
        if (go2) begin
            chk("R3 l2 fetch valid", {31'd0, mem_req_valid}, 32'd1);
            chk("R3 l2 fetch addr", mem_req_addr, a2);
            repeat (lat) @(negedge clk);
            mem_rsp_valid = 1; mem_rsp_data = l2; mem_rsp_err = l2e;
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
        end else begin
            chk("R5 no l2 fetch", {31'd0, mem_req_valid}, 32'd0);
        end
        chk("R4 done valid", {31'd0, done_valid}, 32'd1);
        chk("R6 R7 fault flag", {31'd0, done_fault}, {31'd0, efault});
        chk("R8 bus err flag", {31'd0, done_bus_err}, {31'd0, ebus});
        chk("R4 R11 pa", done_pa, epa);
        chk("R4 R11 attr", {26'd0, done_attr}, {26'd0, eattr});
        chk("R9 flt va", flt_va, exp_fva);
        chk("R9 flt write", {31'd0, flt_write}, {31'd0, exp_fwr});
        chk("R9 flt id", {27'd0, flt_id}, {27'd0, exp_fid});
        chk("R10 ready at done", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        chk("R4 done pulse", {31'd0, done_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 fetch idle", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 done idle", {31'd0, done_valid}, 32'd0);
        chk("R1 flt va", flt_va, 32'd0);
        chk("R1 flt write id", {26'd0, flt_write, flt_id}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // Stray response while idle must be ignored.
        mem_rsp_valid = 1; mem_rsp_data = 32'hFFFF_FFFF;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = 0;
        @(negedge clk);
        chk("R10 stray rsp no done", {31'd0, done_valid}, 32'd0);
        chk("R10 stray rsp no fetch", {31'd0, mem_req_valid}, 32'd0);
        chk("R10 stray rsp ready", {31'd0, req_ready}, 32'd1);

        // Kinds: 0 ok RW, 1 L1 absent, 2 L2 absent, 3 read-only, 4 write-only,
        //        5 L1 bus error, 6 L2 bus error, 7 leaf present without permission.
        for (int p = 0; p < 4; p++) begin
            for (int kind = 0; kind < 8; kind++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [9:0]  i1, i2;
                    logic [11:0] off;
                    logic [31:0] va, base, l1, l2;
                    logic [2:0]  perm;
                    i1   = (p == 0) ? 10'd0 : (p == 1) ? 10'd1 : (p == 2) ? 10'd511 : 10'd1023;
                    i2   = 10'((i1 * 7 + kind * 3 + w * 100) % 1024);
                    off  = 12'((i1 * 13 + kind * 257 + w * 5) % 4096);
                    va   = {i1, i2, off};
                    base = 32'h8000_0000 ^ (32'(kind) << 20) ^ (32'(p) << 14);
                    l1   = 32'h0010_0000 + (32'(kind) << 16) + (32'(i1) << 12) + 32'(w * 4);
                    l1   = (kind == 1) ? (l1 & 32'hFFFF_FFFE) : (l1 | 32'd1);
                    perm = (kind == 3) ? 3'b011 : (kind == 4) ? 3'b101 : (kind == 7) ? 3'b001 : 3'b111;
                    if (kind == 2) perm = 3'b110;
                    l2   = {20'(32'hA5000 + i1 * 31 + kind * 7 + w), 3'b101,
                            6'((kind * 11 + w * 3 + p) % 64), perm};
                    walk(va, w[0], 5'((p + kind + w) % 32), base, l1, kind == 5, l2, kind == 6,
                         1 + (kind + w) % 3, (kind == 0) && (p == 2));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule